// File: doc/BRIEF.md
# Floating-Point Register High-Half Transfer Unit

This block holds a 32-entry floating-point register file and carries out the two coprocessor-1 transfers that move the upper half of a floating-point value to or from an integer register. The core pipeline presents an instruction word, the value of its integer source register and a coprocessor-usable enable. The unit decodes the instruction and, for a move-from-high, returns a sign-extended 64-bit result with a write strobe and the destination index in the same cycle. For a move-to-high, it updates the register file on the next rising clock edge.

A mode input selects the register model. With `fr64_mode` high every entry is a full 64-bit register. With it low every entry acts as a 32-bit register held in bits 31:0. The upper half of an even register then lives in the odd register that follows it. Naming an odd register in this mode produces fixed sentinel values instead of a pair access. A plain load port writes whole entries so that tests can preload the file, and a combinational peek port reads any entry back.

Top module: `fpr_hi_xfer`

## Requirements
- R1: An instruction acts only when `insn_valid` is high, `insn[31:26]` is 6'b010001, `insn[10:0]` is zero and `insn[25:21]` is 5'b00011 (move-from-high) or 5'b00111 (move-to-high). The integer index is `insn[20:16]` and the FP index is `insn[15:11]`. Any other word leaves `gpr_we`, `gpr_idx`, `gpr_data` and `cu_fault` at zero and changes no entry.
- R2: With `fr64_mode`=1, a move-from-high drives `gpr_we`=1, `gpr_idx`=rt and `gpr_data` = entry[fs][63:32] sign-extended to 64 bits, in the same cycle.
- R3: With `fr64_mode`=1, a move-to-high sets entry[fs][63:32] to `rt_value[31:0]` at the next rising edge. Bits 31:0 of that entry, and all other entries, are kept. `gpr_we` stays 0.
- R4: With `fr64_mode`=0 and an even fs, a move-from-high returns entry[fs+1][31:0] sign-extended to 64 bits.
- R5: With `fr64_mode`=0 and an even fs, a move-to-high sets entry[fs+1][31:0] to `rt_value[31:0]` at the next edge and keeps bits 63:32 of that entry.
- R6: With `fr64_mode`=0 and an odd fs, a move-from-high returns 64'h0000_0000_0BAD_F00D.
- R7: With `fr64_mode`=0 and an odd fs, a move-to-high sets entry[fs][31:0] to 32'hDEAD_C0DE and keeps bits 63:32.
- R8: When `cu_usable` is 0, a well-formed transfer raises `cu_fault` in the same cycle, keeps `gpr_we` and `gpr_data` at zero, and changes no entry. When `cu_usable` is 1, `cu_fault` stays 0.
- R9: With `ld_we` high, entry[`ld_idx`] takes `ld_data` at the next edge. If a move-to-high writes the same entry in the same cycle, the transfer's half wins and the other half takes `ld_data`.
- R10: Reset clears every entry to zero. `pk_data` shows entry[`pk_idx`] combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fr64_mode | input | 1 | 1: 64-bit registers, 0: paired 32-bit registers |
| cu_usable | input | 1 | Coprocessor-usable enable |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn | input | 32 | Instruction word |
| rt_value | input | 64 | Value of the integer source register |
| gpr_we | output | 1 | Integer register write strobe (move-from-high) |
| gpr_idx | output | 5 | Integer register index to write |
| gpr_data | output | 64 | Result for the integer register |
| cu_fault | output | 1 | Transfer attempted while coprocessor unusable |
| ld_we | input | 1 | Load port write enable |
| ld_idx | input | 5 | Load port entry index |
| ld_data | input | 64 | Load port data |
| pk_idx | input | 5 | Peek port entry index |
| pk_data | output | 64 | Peek port data |

## Verification
Move-from-high results and the fault flag are combinational, so they are due in the cycle the instruction is presented. The bench drives each instruction on a falling edge and samples `gpr_we`, `gpr_idx`, `gpr_data` and `cu_fault` 2 ns later, well before the next rising edge. Move-to-high and load-port effects appear only after that rising edge. The bench therefore removes the stimulus just after the edge and reads the affected entries through the peek port on a later falling edge. Each sweep covers all 32 FP indices in both modes against a bench-side array updated by the requirement rules.

// File: rtl/fpr_hx_pkg.sv
package fpr_hx_pkg;
   localparam int          INSN_W    = 32;
   localparam int          FIELD_W   = 5;
   localparam logic [5:0]  OPC_COP1  = 6'b010001;
   localparam logic [4:0]  SUB_MF_HI = 5'b00011;
   localparam logic [4:0]  SUB_MT_HI = 5'b00111;

   typedef struct packed {
      logic                do_mf;
      logic                do_mt;
      logic                fault;
      logic [FIELD_W-1:0]  rt;
      logic [FIELD_W-1:0]  fs;
   } xfer_req_t;
endpackage

// File: rtl/fpr_hx_decode.sv
module fpr_hx_decode
   import fpr_hx_pkg::*;
(
   input  logic              valid,
   input  logic [INSN_W-1:0] insn,
   input  logic              cu_ok,
   output xfer_req_t         req
);
   logic form_ok;
   logic is_mf;
   logic is_mt;

   always_comb begin
      form_ok = valid && (insn[31:26] == OPC_COP1) && (insn[10:0] == 11'd0);
      is_mf   = form_ok && (insn[25:21] == SUB_MF_HI);
      is_mt   = form_ok && (insn[25:21] == SUB_MT_HI);
      req.rt    = insn[20:16];
      req.fs    = insn[15:11];
      req.do_mf = is_mf && cu_ok;
      req.do_mt = is_mt && cu_ok;
      req.fault = (is_mf || is_mt) && !cu_ok;
   end
endmodule

// File: rtl/fpr_hx_route.sv
module fpr_hx_route #(
   parameter int          DATA_W  = 64,
   parameter int          IDX_W   = 5,
   parameter logic [31:0] SENT_RD = 32'h0BAD_F00D,
   parameter logic [31:0] SENT_WR = 32'hDEAD_C0DE
) (
   input  logic                fr64,
   input  logic                do_mf,
   input  logic                do_mt,
   input  logic [IDX_W-1:0]    fs,
   input  logic [DATA_W/2-1:0] rt_lo,
   input  logic [DATA_W-1:0]   rd_d,
   output logic [IDX_W-1:0]    sel_idx,
   output logic                hi_we,
   output logic                lo_we,
   output logic [DATA_W/2-1:0] hi_d,
   output logic [DATA_W/2-1:0] lo_d,
   output logic [DATA_W-1:0]   mf_data
);
   localparam int HALF_W = DATA_W / 2;

   logic              odd_fs;
   logic [IDX_W-1:0]  pair_idx;
   logic [HALF_W-1:0] half_sel;

   always_comb begin
      odd_fs   = fs[0];
      pair_idx = {fs[IDX_W-1:1], 1'b1};
      sel_idx  = fr64 ? fs : pair_idx;

      if (fr64)        half_sel = rd_d[DATA_W-1:HALF_W];
      else if (odd_fs) half_sel = SENT_RD;
      else             half_sel = rd_d[HALF_W-1:0];

      mf_data = do_mf ? {{HALF_W{half_sel[HALF_W-1]}}, half_sel} : '0;

      hi_we = do_mt && fr64;
      lo_we = do_mt && !fr64;
      hi_d  = rt_lo;
      lo_d  = odd_fs ? SENT_WR : rt_lo;
   end
endmodule

// File: rtl/fpr_hx_regfile.sv
module fpr_hx_regfile #(
   parameter int NREG        = 32,
   parameter int DATA_W      = 64,
   parameter int IDX_W       = 5,
   parameter bit RESET_CLEAR = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IDX_W-1:0]    x_idx,
   input  logic                x_hi_we,
   input  logic                x_lo_we,
   input  logic [DATA_W/2-1:0] x_hi_d,
   input  logic [DATA_W/2-1:0] x_lo_d,
   input  logic                l_we,
   input  logic [IDX_W-1:0]    l_idx,
   input  logic [DATA_W-1:0]   l_d,
   input  logic [IDX_W-1:0]    ra_idx,
   output logic [DATA_W-1:0]   ra_d,
   input  logic [IDX_W-1:0]    rb_idx,
   output logic [DATA_W-1:0]   rb_d
);
   localparam int HALF_W = DATA_W / 2;

   logic [DATA_W-1:0] ent [NREG];

   for (genvar e = 0; e < NREG; e++) begin : g_ent
      logic              hit_x;
      logic              hit_l;
      logic              hi_en;
      logic              lo_en;
      logic [HALF_W-1:0] hi_n;
      logic [HALF_W-1:0] lo_n;
      logic [HALF_W-1:0] hi_q;
      logic [HALF_W-1:0] lo_q;

      always_comb begin
         hit_x = (x_idx == IDX_W'(e));
         hit_l = l_we && (l_idx == IDX_W'(e));
         hi_en = (hit_x && x_hi_we) || hit_l;
         lo_en = (hit_x && x_lo_we) || hit_l;
         hi_n  = (hit_x && x_hi_we) ? x_hi_d : l_d[DATA_W-1:HALF_W];
         lo_n  = (hit_x && x_lo_we) ? x_lo_d : l_d[HALF_W-1:0];
      end

      if (RESET_CLEAR) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hi_q <= '0;
               lo_q <= '0;
            end else begin
               if (hi_en) hi_q <= hi_n;
               if (lo_en) lo_q <= lo_n;
            end
         end
      end else begin : g_nrst
         always_ff @(posedge clk) begin
            if (hi_en) hi_q <= hi_n;
            if (lo_en) lo_q <= lo_n;
         end
      end

      assign ent[e] = {hi_q, lo_q};
   end

   assign ra_d = ent[ra_idx];
   assign rb_d = ent[rb_idx];
endmodule

// File: rtl/fpr_hi_xfer.sv
module fpr_hi_xfer
   import fpr_hx_pkg::*;
#(
   parameter int          NREG        = 32,
   parameter int          DATA_W      = 64,
   parameter bit          RESET_CLEAR = 1'b1,
   parameter logic [31:0] SENT_RD     = 32'h0BAD_F00D,
   parameter logic [31:0] SENT_WR     = 32'hDEAD_C0DE
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        fr64_mode,
   input  logic        cu_usable,
   input  logic        insn_valid,
   input  logic [31:0] insn,
   input  logic [63:0] rt_value,
   output logic        gpr_we,
   output logic [4:0]  gpr_idx,
   output logic [63:0] gpr_data,
   output logic        cu_fault,
   input  logic        ld_we,
   input  logic [4:0]  ld_idx,
   input  logic [63:0] ld_data,
   input  logic [4:0]  pk_idx,
   output logic [63:0] pk_data
);
   localparam int IDX_W  = $clog2(NREG);
   localparam int HALF_W = DATA_W / 2;

   if (NREG != (1 << FIELD_W)) begin : g_bad_nreg
      $error("fpr_hi_xfer: NREG must match the 5-bit register field");
   end
   if (DATA_W != 64) begin : g_bad_width
      $error("fpr_hi_xfer: DATA_W must be 64");
   end

   xfer_req_t         req;
   logic [IDX_W-1:0]  sel_idx;
   logic              hi_we;
   logic              lo_we;
   logic [HALF_W-1:0] hi_d;
   logic [HALF_W-1:0] lo_d;
   logic [DATA_W-1:0] rd_d;
   logic [DATA_W-1:0] mf_data;
   logic              unused_rt_hi;

   assign unused_rt_hi = ^rt_value[63:32];

   fpr_hx_decode u_dec (
      .valid (insn_valid),
      .insn  (insn),
      .cu_ok (cu_usable),
      .req   (req)
   );

   fpr_hx_route #(
      .DATA_W  (DATA_W),
      .IDX_W   (IDX_W),
      .SENT_RD (SENT_RD),
      .SENT_WR (SENT_WR)
   ) u_route (
      .fr64    (fr64_mode),
      .do_mf   (req.do_mf),
      .do_mt   (req.do_mt),
      .fs      (req.fs),
      .rt_lo   (rt_value[HALF_W-1:0]),
      .rd_d    (rd_d),
      .sel_idx (sel_idx),
      .hi_we   (hi_we),
      .lo_we   (lo_we),
      .hi_d    (hi_d),
      .lo_d    (lo_d),
      .mf_data (mf_data)
   );

   fpr_hx_regfile #(
      .NREG        (NREG),
      .DATA_W      (DATA_W),
      .IDX_W       (IDX_W),
      .RESET_CLEAR (RESET_CLEAR)
   ) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .x_idx   (sel_idx),
      .x_hi_we (hi_we),
      .x_lo_we (lo_we),
      .x_hi_d  (hi_d),
      .x_lo_d  (lo_d),
      .l_we    (ld_we),
      .l_idx   (ld_idx),
      .l_d     (ld_data),
      .ra_idx  (sel_idx),
      .ra_d    (rd_d),
      .rb_idx  (pk_idx),
      .rb_d    (pk_data)
   );

   assign gpr_we   = req.do_mf;
   assign gpr_idx  = req.do_mf ? req.rt : '0;
   assign gpr_data = mf_data;
   assign cu_fault = req.fault;
endmodule

// File: rtl/fpr_hi_xfer_chk.sv
module fpr_hi_xfer_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        fr64_mode,
   input logic        cu_usable,
   input logic        insn_valid,
   input logic [31:0] insn,
   input logic [63:0] rt_value,
   input logic        gpr_we,
   input logic [63:0] gpr_data,
   input logic        cu_fault,
   input logic        ld_we,
   input logic [4:0]  pk_idx,
   input logic [63:0] pk_data
);
   logic well_formed;
   logic is_mf;
   logic is_mt;

   assign well_formed = insn_valid && (insn[31:26] == 6'b010001) && (insn[10:0] == 11'd0);
   assign is_mf = well_formed && (insn[25:21] == 5'b00011);
   assign is_mt = well_formed && (insn[25:21] == 5'b00111);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_valid |-> (!gpr_we && !cu_fault && gpr_data == 64'd0)); // R1

   AST_RESULT_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
      gpr_we |-> (gpr_data[63:32] == {32{gpr_data[31]}})); // R2

   AST_MT64_KEEP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (is_mt && cu_usable && fr64_mode && !ld_we && pk_idx == insn[15:11])
      |=> ($stable(pk_idx) |-> (pk_data[63:32] == $past(rt_value[31:0])
                               && pk_data[31:0] == $past(pk_data[31:0])))); // R3

   AST_MT32_EVEN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (is_mt && cu_usable && !fr64_mode && !insn[11] && !ld_we
       && pk_idx == {insn[15:12], 1'b1})
      |=> ($stable(pk_idx) |-> (pk_data[31:0] == $past(rt_value[31:0])
                               && pk_data[63:32] == $past(pk_data[63:32])))); // R5

   AST_ODD_READ_SENTINEL: assert property (@(posedge clk) disable iff (!rst_n)
      (is_mf && cu_usable && !fr64_mode && insn[11])
      |-> (gpr_data == 64'h0000_0000_0BAD_F00D)); // R6

   AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (is_mf || is_mt) && !cu_usable |-> (cu_fault && !gpr_we)); // R8

   AST_FAULT_STATE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (cu_fault && !ld_we) |=> ($stable(pk_idx) |-> $stable(pk_data))); // R8
endmodule

bind fpr_hi_xfer fpr_hi_xfer_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fr64_mode  (fr64_mode),
   .cu_usable  (cu_usable),
   .insn_valid (insn_valid),
   .insn       (insn),
   .rt_value   (rt_value),
   .gpr_we     (gpr_we),
   .gpr_data   (gpr_data),
   .cu_fault   (cu_fault),
   .ld_we      (ld_we),
   .pk_idx     (pk_idx),
   .pk_data    (pk_data)
);

// File: tb/fpr_hi_xfer_bench.sv
module fpr_hi_xfer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fr64_mode = 1'b1;
   logic        cu_usable = 1'b1;
   logic        insn_valid = 1'b0;
   logic [31:0] insn = '0;
   logic [63:0] rt_value = '0;
   logic        gpr_we;
   logic [4:0]  gpr_idx;
   logic [63:0] gpr_data;
   logic        cu_fault;
   logic        ld_we = 1'b0;
   logic [4:0]  ld_idx = '0;
   logic [63:0] ld_data = '0;
   logic [4:0]  pk_idx = '0;
   logic [63:0] pk_data;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   logic [63:0] model [32];
   logic        o_we;
   logic [4:0]  o_idx;
   logic [63:0] o_data;
   logic        o_fault;

   always #5 clk = ~clk;

   fpr_hi_xfer u_fpr_hi_xfer (
      .clk(clk), .rst_n(rst_n), .fr64_mode(fr64_mode), .cu_usable(cu_usable),
      .insn_valid(insn_valid), .insn(insn), .rt_value(rt_value),
      .gpr_we(gpr_we), .gpr_idx(gpr_idx), .gpr_data(gpr_data), .cu_fault(cu_fault),
      .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
      .pk_idx(pk_idx), .pk_data(pk_data)
   );

   function automatic logic [31:0] enc(input logic [4:0] sub, input logic [4:0] rt, input logic [4:0] fs);
      return {6'b010001, sub, rt, fs, 11'd0};
   endfunction

   function automatic logic [63:0] sx(input logic [31:0] v);
      return {{32{v[31]}}, v};
   endfunction

   function automatic logic [63:0] pat(input int i);
      logic [31:0] h;
      logic [31:0] l;
      h = 32'h9E37_79B9 * 32'(i + 1);
      l = 32'h7F4A_7C15 ^ (32'h0101_0101 * 32'(i));
      return {h, l};
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one instruction (optionally with a load), capture outputs, commit at the edge
   task automatic issue(input logic [31:0] w, input logic [63:0] v,
                        input logic lw, input logic [4:0] li, input logic [63:0] ld);
      @(negedge clk);
      insn_valid = 1'b1; insn = w; rt_value = v;
      ld_we = lw; ld_idx = li; ld_data = ld;
      #2;
      o_we = gpr_we; o_idx = gpr_idx; o_data = gpr_data; o_fault = cu_fault;
      @(posedge clk);
      #1;
      insn_valid = 1'b0; insn = '0; ld_we = 1'b0;
   endtask

   task automatic peek(input logic [4:0] k, output logic [63:0] d);
      @(negedge clk);
      pk_idx = k;
      #1;
      d = pk_data;
   endtask

   task automatic peek_all(input string req);
      logic [63:0] d;
      for (int k = 0; k < 32; k++) begin
         peek(5'(k), d);
         check(req, d, model[k]);
      end
   endtask

   initial begin
      logic [63:0] d;
      logic [63:0] v;
      for (int k = 0; k < 32; k++) model[k] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R10: reset state
      peek_all("R10 reset clear");

      // R9: load every entry
      for (int k = 0; k < 32; k++) begin
         @(negedge clk);
         ld_we = 1'b1; ld_idx = 5'(k); ld_data = pat(k);
         @(posedge clk);
         #1 ld_we = 1'b0;
         model[k] = pat(k);
      end
      peek_all("R9 load port");

      // R2: 64-bit move-from-high sweep
      fr64_mode = 1'b1;
      for (int k = 0; k < 32; k++) begin
         issue(enc(5'b00011, 5'(k ^ 5), 5'(k)), 64'd0, 1'b0, 5'd0, 64'd0);
         check("R2 mf64 data", o_data, sx(model[k][63:32]));
         check("R2 mf64 we", 64'(o_we), 64'd1);
         check("R2 mf64 idx", 64'(o_idx), 64'(k ^ 5));
         check("R8 no fault when usable", 64'(o_fault), 64'd0);
      end

      // R3: 64-bit move-to-high sweep
      for (int k = 0; k < 32; k++) begin
         v = {32'hA5A5_0000 | 32'(k), 32'h8000_1000 + 32'(k * 7)};
         issue(enc(5'b00111, 5'(k), 5'(k)), v, 1'b0, 5'd0, 64'd0);
         check("R3 mt64 no gpr write", 64'(o_we), 64'd0);
         model[k][63:32] = v[31:0];
      end
      peek_all("R3 mt64 state");

      // R4 / R6: 32-bit move-from-high sweep
      fr64_mode = 1'b0;
      for (int k = 0; k < 32; k++) begin
         issue(enc(5'b00011, 5'(31 - k), 5'(k)), 64'd0, 1'b0, 5'd0, 64'd0);
         if (k % 2 == 0) check("R4 mf32 even", o_data, sx(model[k + 1][31:0]));
         else            check("R6 mf32 odd sentinel", o_data, 64'h0000_0000_0BAD_F00D);
         check("R4 mf32 idx", 64'(o_idx), 64'(31 - k));
      end

      // R5 / R7: 32-bit move-to-high sweep, checked entry by entry
      for (int k = 0; k < 32; k++) begin
         v = {32'hFFFF_FFFF, 32'hC000_0000 ^ 32'(k * 32'h0001_0203)};
         issue(enc(5'b00111, 5'd3, 5'(k)), v, 1'b0, 5'd0, 64'd0);
         if (k % 2 == 0) begin
            model[k + 1][31:0] = v[31:0];
            peek(5'(k + 1), d);
            check("R5 mt32 even pair", d, model[k + 1]);
         end else begin
            model[k][31:0] = 32'hDEAD_C0DE;
            peek(5'(k), d);
            check("R7 mt32 odd sentinel", d, model[k]);
         end
      end
      peek_all("R5 R7 mt32 state");

      // R8: coprocessor unusable
      cu_usable = 1'b0;
      for (int k = 0; k < 4; k++) begin
         fr64_mode = k[0];
         issue(enc(5'b00011, 5'd1, 5'(k * 9)), 64'd0, 1'b0, 5'd0, 64'd0);
         check("R8 mf fault", 64'(o_fault), 64'd1);
         check("R8 mf no we", 64'(o_we), 64'd0);
         check("R8 mf data zero", o_data, 64'd0);
         issue(enc(5'b00111, 5'd1, 5'(k * 9)), 64'h1234_5678_9ABC_DEF0, 1'b0, 5'd0, 64'd0);
         check("R8 mt fault", 64'(o_fault), 64'd1);
      end
      cu_usable = 1'b1;
      peek_all("R8 state kept");

      // R1: malformed or invalid words
      fr64_mode = 1'b1;
      issue({6'b010010, 5'b00111, 5'd2, 5'd4, 11'd0}, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 5'd0, 64'd0);
      check("R1 wrong opcode we", 64'(o_we), 64'd0);
      issue(enc(5'b00100, 5'd2, 5'd4), 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 5'd0, 64'd0);
      check("R1 wrong subop we", 64'(o_we), 64'd0);
      issue(enc(5'b00111, 5'd2, 5'd4) | 32'h1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 5'd0, 64'd0);
      check("R1 nonzero tail fault", 64'(o_fault), 64'd0);
      issue(enc(5'b00011, 5'd2, 5'd4) | 32'h400, 64'd0, 1'b0, 5'd0, 64'd0);
      check("R1 nonzero tail data", o_data, 64'd0);
      @(negedge clk);
      insn = enc(5'b00111, 5'd2, 5'd4); rt_value = '1; insn_valid = 1'b0;
      #2;
      check("R1 invalid strobe idx", 64'(gpr_idx), 64'd0);
      @(posedge clk);
      #1 insn = '0;
      peek_all("R1 state kept");

      // R9: load and transfer on the same entry
      fr64_mode = 1'b1;
      issue(enc(5'b00111, 5'd0, 5'd4), 64'h0000_0000_1357_9BDF, 1'b1, 5'd4, 64'h2222_3333_4444_5555);
      model[4] = {32'h1357_9BDF, 32'h4444_5555};
      peek(5'd4, d);
      check("R9 collision 64", d, model[4]);
      fr64_mode = 1'b0;
      issue(enc(5'b00111, 5'd0, 5'd6), 64'h0000_0000_0246_8ACE, 1'b1, 5'd7, 64'h6666_7777_8888_9999);
      model[7] = {32'h6666_7777, 32'h0246_8ACE};
      peek(5'd7, d);
      check("R9 collision 32", d, model[7]);
      peek_all("R9 final state");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule